// File: doc/BRIEF.md
# Bus-Attached 16x16 Multiply-Accumulate Unit

This block lets a 16-bit processor hand off multiplications to dedicated hardware over a small synchronous register bus. Software picks the operation by choosing which of four addresses receives the first operand. The four operations are unsigned multiply, signed multiply, unsigned multiply-accumulate and signed multiply-accumulate. Writing the second operand starts the operation. The 32-bit product, or the running sum, is then read back as two 16-bit words. A third readable word holds either the sign of the result or the carry from the latest accumulation.

The first operand and its mode are kept after each operation. A loop of second-operand writes therefore forms a dot-product style accumulation without rewriting the first operand. A two-stage pipeline sits behind the bus. Results appear at the start of the third cycle after the second-operand write. A busy flag is readable during the two cycles in between.

Top module: `mulPeriph`

## Requirements
- R1: After reset, both result words, the extension word and the busy flag read as zero.
- R2: Word addresses 0, 1, 2 and 3 are first-operand writes that select unsigned multiply, signed multiply, unsigned accumulate and signed accumulate respectively. A write to address 4 starts the operation. Reads of address 5 return the low result word, address 6 the high result word, address 7 the extension word, and address 4 the busy flag in bit 0. Every other read, including addresses 0 to 3, returns 0.
- R3: Unsigned multiply replaces the 32-bit result with the unsigned product of the two operands and sets the extension word to 0x0000.
- R4: Signed multiply replaces the result with the two's complement product. The extension word becomes 0xFFFF when that product is negative and 0x0000 otherwise.
- R5: Unsigned accumulate adds the unsigned product to the current 32-bit result, modulo 2^32. The extension word becomes 0x0001 if that addition carried out of bit 31 and 0x0000 otherwise.
- R6: Signed accumulate adds the signed product to the current result, modulo 2^32. The extension word becomes 0xFFFF when the new result is negative and 0x0000 otherwise.
- R7: The extension word depends only on the most recent operation. An accumulation without carry that follows one with carry leaves it at 0x0000.
- R8: Write the second operand in cycle c. The result and extension words change at the start of cycle c+3 and still show their previous values in cycles c+1 and c+2. The busy flag reads 1 in cycles c+1 and c+2 and 0 from cycle c+3.
- R9: The first operand and the selected mode persist across operations, so repeated second-operand writes reuse them.
- R10: A first-operand write on its own, or a write to a result address, leaves the result and extension words unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 3 | Word address for both reads and writes |
| busWe | input | 1 | Write enable, sampled on the rising edge |
| busWrData | input | 16 | Write data |
| busRdData | output | 16 | Read data for busAddr, combinational |

## Verification
The bench targets the operand extremes. 0xFFFF times 0xFFFF must give 0xFFFE0001 unsigned and 1 signed. 0x8000 squared, signed, must give 0x40000000 with a positive extension. A design that got either sign extension wrong would return the other mode's answer. It drives an unsigned accumulation that carries and then one that does not, which catches an extension word that sticks or accumulates. It samples results in each cycle after the start. A pipeline one stage short or long would expose the new value early or late, and the busy flag would be misplaced. Writes to the first operand and to the result addresses are followed by readback. Randomised mode changes mixed with repeated second-operand writes show whether the operand and mode are really retained.

// File: rtl/mulPeriphPkg.sv
package mulPeriphPkg;

  typedef enum logic [1:0] {
    MODE_UMUL = 2'd0,
    MODE_SMUL = 2'd1,
    MODE_UMAC = 2'd2,
    MODE_SMAC = 2'd3
  } opMode_e;

  localparam int unsigned ADDR_OP2     = 4;
  localparam int unsigned ADDR_RES_LO  = 5;
  localparam int unsigned ADDR_RES_HI  = 6;
  localparam int unsigned ADDR_EXT     = 7;
  localparam int unsigned OP1_ADDR_CNT = 4;

  typedef struct packed {
    logic    loadOp1;
    opMode_e op1Mode;
    logic    start;
    logic    doProduct;
    logic    doCommit;
  } ctrlStrobes_t;

endpackage

// File: rtl/mulCtrl.sv
module mulCtrl
  import mulPeriphPkg::*;
#(
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output ctrlStrobes_t      strobes,
  output logic              busy
);

  logic prodPendQ;
  logic commitPendQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prodPendQ   <= 1'b0;
      commitPendQ <= 1'b0;
    end else begin
      prodPendQ   <= strobes.start;
      commitPendQ <= prodPendQ;
    end
  end

  always_comb begin
    strobes.loadOp1   = busWe && (busAddr < ADDR_W'(OP1_ADDR_CNT));
    strobes.op1Mode   = opMode_e'(busAddr[1:0]);
    strobes.start     = busWe && (busAddr == ADDR_W'(ADDR_OP2));
    strobes.doProduct = prodPendQ;
    strobes.doCommit  = commitPendQ;
  end

  assign busy = prodPendQ | commitPendQ;

  assert_busy_after_start_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.start |=> busy);

endmodule

// File: rtl/mulDatapath.sv
module mulDatapath
  import mulPeriphPkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  input  ctrlStrobes_t      strobes,
  input  logic              busy,
  output logic [DATA_W-1:0] rdData
);

  localparam int unsigned RES_W  = 2 * DATA_W;
  localparam int unsigned WIDE_W = RES_W + 2;

  logic [DATA_W-1:0] op1Q;
  opMode_e           modeQ;
  logic [DATA_W-1:0] stageAQ, stageBQ;
  opMode_e           stageModeQ;
  logic [RES_W-1:0]  prodQ;
  opMode_e           prodModeQ;
  logic [RES_W-1:0]  resultQ;
  logic [DATA_W-1:0] sumExtQ;

  // Product stage: extend by one bit by sign or zero, then multiply wide.
  logic                     signedOp;
  logic signed [DATA_W:0]   extA, extB;
  logic signed [WIDE_W-1:0] wideA, wideB, wideProd;

  assign signedOp = stageModeQ[0];
  assign extA     = {signedOp & stageAQ[DATA_W-1], stageAQ};
  assign extB     = {signedOp & stageBQ[DATA_W-1], stageBQ};
  assign wideA    = {{(WIDE_W-DATA_W-1){extA[DATA_W]}}, extA};
  assign wideB    = {{(WIDE_W-DATA_W-1){extB[DATA_W]}}, extB};
  assign wideProd = wideA * wideB;

  // Commit stage: overwrite or accumulate into the result.
  logic [RES_W:0]    accSum;
  logic [RES_W-1:0]  nextRes;
  logic [DATA_W-1:0] nextExt;

  assign accSum = {1'b0, resultQ} + {1'b0, prodQ};

  always_comb begin
    unique case (prodModeQ)
      MODE_UMUL: begin
        nextRes = prodQ;
        nextExt = '0;
      end
      MODE_SMUL: begin
        nextRes = prodQ;
        nextExt = {DATA_W{prodQ[RES_W-1]}};
      end
      MODE_UMAC: begin
        nextRes = accSum[RES_W-1:0];
        nextExt = DATA_W'(accSum[RES_W]);
      end
      default: begin
        nextRes = accSum[RES_W-1:0];
        nextExt = {DATA_W{accSum[RES_W-1]}};
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      op1Q       <= '0;
      modeQ      <= MODE_UMUL;
      stageAQ    <= '0;
      stageBQ    <= '0;
      stageModeQ <= MODE_UMUL;
      prodQ      <= '0;
      prodModeQ  <= MODE_UMUL;
      resultQ    <= '0;
      sumExtQ    <= '0;
    end else begin
      if (strobes.loadOp1) begin
        op1Q  <= wrData;
        modeQ <= strobes.op1Mode;
      end
      if (strobes.start) begin
        stageAQ    <= op1Q;
        stageBQ    <= wrData;
        stageModeQ <= modeQ;
      end
      if (strobes.doProduct) begin
        prodQ     <= wideProd[RES_W-1:0];
        prodModeQ <= stageModeQ;
      end
      if (strobes.doCommit) begin
        resultQ <= nextRes;
        sumExtQ <= nextExt;
      end
    end
  end

  always_comb begin
    unique case (rdAddr)
      ADDR_W'(ADDR_OP2):    rdData = DATA_W'(busy);
      ADDR_W'(ADDR_RES_LO): rdData = resultQ[DATA_W-1:0];
      ADDR_W'(ADDR_RES_HI): rdData = resultQ[RES_W-1:DATA_W];
      ADDR_W'(ADDR_EXT):    rdData = sumExtQ;
      default:              rdData = '0;
    endcase
  end

  assert_umul_ext_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.doCommit && prodModeQ == MODE_UMUL) |=> sumExtQ == '0);

  assert_smul_ext_sign_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.doCommit && prodModeQ == MODE_SMUL) |=> sumExtQ == {DATA_W{resultQ[RES_W-1]}});

  assert_umac_ext_flag_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.doCommit && prodModeQ == MODE_UMAC) |=> sumExtQ[DATA_W-1:1] == '0);

  assert_smac_ext_sign_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.doCommit && prodModeQ == MODE_SMAC) |=> sumExtQ == {DATA_W{resultQ[RES_W-1]}});

  assert_result_held_R10: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.doCommit |=> ($stable(resultQ) && $stable(sumExtQ)));

endmodule

// File: rtl/mulPeriph.sv
module mulPeriph
  import mulPeriphPkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData
);

  ctrlStrobes_t strobes;
  logic         busy;

  mulCtrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busWe   (busWe),
    .strobes (strobes),
    .busy    (busy)
  );

  mulDatapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .wrData  (busWrData),
    .rdAddr  (busAddr),
    .strobes (strobes),
    .busy    (busy),
    .rdData  (busRdData)
  );

endmodule

// File: tb/mulPeriph_tb_top.sv
`timescale 1ns/100ps
module mulPeriph_tb_top;
  localparam int DW = 16;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic          busWe = 1'b0;
  logic [DW-1:0] busWrData = '0;
  logic [DW-1:0] busRdData;

  int vecCount = 0;
  int failCount = 0;
  bit done = 1'b0;

  logic [DW-1:0]   mOp1 = '0;
  logic [1:0]      mMode = 2'd0;
  logic [2*DW-1:0] mRes = '0;
  logic [DW-1:0]   mExt = '0;

  always #2 clk = ~clk;

  mulPeriph dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWrData(busWrData), .busRdData(busRdData)
  );

  task automatic check(input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    vecCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    busAddr = a;
    #0.4;
    d = busRdData;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    busAddr = a; busWe = 1'b1; busWrData = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic checkAll(input string req);
    logic [DW-1:0] v;
    rd(3'd5, v); check(req, "result low", v, mRes[DW-1:0]);
    rd(3'd6, v); check(req, "result high", v, mRes[2*DW-1:DW]);
    rd(3'd7, v); check(req, "extension", v, mExt);
    rd(3'd4, v); check(req, "busy idle", v, 16'h0000);
  endtask

  function automatic void applyModel(input logic [DW-1:0] b);
    logic [2*DW-1:0] up;
    logic [2*DW-1:0] sp;
    logic [2*DW:0]   acc;
    up = {16'h0, mOp1} * {16'h0, b};
    sp = $signed({{16{mOp1[15]}}, mOp1}) * $signed({{16{b[15]}}, b});
    case (mMode)
      2'd0: begin mRes = up; mExt = 16'h0000; end
      2'd1: begin mRes = sp; mExt = {16{sp[31]}}; end
      2'd2: begin acc = {1'b0, mRes} + {1'b0, up}; mRes = acc[31:0]; mExt = {15'h0, acc[32]}; end
      default: begin mRes = mRes + sp; mExt = {16{mRes[31]}}; end
    endcase
  endfunction

  task automatic setOp1(input logic [1:0] mode, input logic [DW-1:0] val);
    wr({1'b0, mode}, val);
    mMode = mode; mOp1 = val;
  endtask

  task automatic runOp(input logic [DW-1:0] b, input string req);
    wr(3'd4, b);
    applyModel(b);
    repeat (2) @(negedge clk);
    checkAll(req);
  endtask

  task automatic timedOp(input logic [DW-1:0] b);
    logic [DW-1:0] oldLo, v;
    oldLo = mRes[DW-1:0];
    wr(3'd4, b);
    applyModel(b);
    for (int k = 1; k <= 2; k++) begin
      rd(3'd4, v); check("R8", "busy while pending", v, 16'h0001);
      rd(3'd5, v); check("R8", "old result while pending", v, oldLo);
      if (k == 1) @(negedge clk);
    end
    @(negedge clk);
    checkAll("R8");
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      failCount++;
      $display("FAIL R8 watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v;
    logic [1:0] md;
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1");

    // R2: first-operand addresses read back as zero
    setOp1(2'd0, 16'hFFFF);
    rd(3'd0, v); check("R2", "op1 address read", v, 16'h0000);
    rd(3'd3, v); check("R2", "mac op1 address read", v, 16'h0000);

    // R3 and R8: unsigned extreme with cycle-level timing
    timedOp(16'hFFFF);

    // R4: signed extremes; R9 reuse of operand 1
    setOp1(2'd1, 16'hFFFF);
    runOp(16'hFFFF, "R4");
    setOp1(2'd1, 16'h8000);
    runOp(16'h8000, "R4");
    runOp(16'h0003, "R9");

    // R5 carry then R7 no carry
    setOp1(2'd0, 16'hFFFF);
    runOp(16'hFFFF, "R3");
    setOp1(2'd2, 16'hFFFF);
    runOp(16'hFFFF, "R5");
    runOp(16'h0001, "R7");

    // R6 signed accumulate driving negative
    setOp1(2'd3, 16'hFFFE);
    runOp(16'h0005, "R6");
    runOp(16'h7FFF, "R6");

    // R10: operand and result-address writes leave results
    setOp1(2'd0, 16'h1234);
    wr(3'd5, 16'hABCD);
    wr(3'd7, 16'h5555);
    repeat (3) @(negedge clk);
    checkAll("R10");

    for (int i = 0; i < 300; i++) begin
      if (($urandom % 3) == 0) begin
        md = 2'($urandom % 4);
        setOp1(md, 16'($urandom));
      end
      case (mMode)
        2'd0: runOp(16'($urandom), "R3");
        2'd1: runOp(16'($urandom), "R4");
        2'd2: runOp(16'($urandom), "R5");
        default: runOp(16'($urandom), "R6");
      endcase
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end

endmodule